// File: doc/BRIEF.md
# Buffered Edge/Center PWM Channel Pair

This block holds two pulse-width channels. Each has an 8-bit counter that moves one step on every cycle where the shared prescaled tick input is high and the channel is enabled. A mode bit picks one of two counting shapes. In edge mode the counter ramps up and wraps. In center mode it climbs to the period value and then descends back to zero. The output is driven at the active level while the count is below the duty value, and at the inactive level otherwise. A polarity bit chooses which level is active.

Period and duty values are written through a single byte-wide write port. A write made while the channel runs lands only in a buffer. The buffered values move into the working copy at the end of the current period, or at once when the counter itself is written. Writing the counter, with any data, restarts the channel. A join input fuses both channels into one 16-bit channel. Channel 1 supplies the high byte and the controls. The whole count is always presented as one 16-bit word taken from a single clock edge.

Top module: `bpwm_pair`

## Requirements
- R1: While `rst_n` is low, `cnt_o` and `pwm_o` are all zero, and every period, duty and buffer value is cleared to zero.
- R2: In edge mode (`center_i` bit 0), with a period P>0, each enabled tick moves the count through 0, 1, …, P−1 and then back to 0, so one period lasts P ticks.
- R3: In center mode (`center_i` bit 1), with P>0, the count climbs from 0 to P and then descends to 0, so one period lasts 2·P ticks. The descent begins on the tick that reaches P.
- R4: A channel whose enable is 0, or that sees no tick, keeps its count. Once it is enabled again, counting resumes from the held value.
- R5: A write with `wr_reg_i`=2 (counter) clears that channel's count to 0 regardless of data. It sets the direction to upward, copies both buffers into the working period and duty at once, and updates the output from the new state after the same edge.
- R6: A write with `wr_reg_i`=0 (period) or 1 (duty) to an enabled channel changes only the buffer. The working value picks up the buffer on the tick that ends the period, meaning the wrap to 0 in either mode.
- R7: The same writes to a disabled channel take effect in the working values immediately. A write with `wr_reg_i`=3 changes nothing.
- R8: In edge mode, with 0<duty<P, the output is at the active level while count<duty and at the inactive level otherwise. The active level is 1 when polarity is 1 and 0 when polarity is 0.
- R9: In center mode, with duty<P, the output is active while rising with count<duty and while falling with count≤duty, which gives 2·duty active ticks per period.
- R10: With a working period of 0 the counter does not move and the output stays at the inactive level.
- R11: With duty≥P>0 the output stays active for the whole period. With duty 0 it stays inactive.
- R12: With `concat_i`=1 the two channels act as one 16-bit channel. Its period and duty are {channel 1 byte, channel 0 byte}, and it uses channel 1's enable, polarity and mode bits. Its output appears on `pwm_o[1]`, while `pwm_o[0]` stays 0. A counter write to either byte clears all 16 bits.
- R13: `cnt_o` carries {channel 1 count, channel 0 count} from the same clock edge, so a carry from the low byte is seen together with the high byte (0x00FF is followed by 0x0100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaled count enable shared by both channels |
| en_i | input | 2 | Per-channel run enable |
| pol_i | input | 2 | Per-channel active level |
| center_i | input | 2 | Per-channel counting shape: 0 edge, 1 center |
| concat_i | input | 1 | Fuse both channels into one 16-bit channel |
| wr_en_i | input | 1 | Write strobe |
| wr_reg_i | input | 2 | Write target: 0 period, 1 duty, 2 counter, 3 none |
| wr_ch_i | input | 1 | Channel (byte) selected by a write |
| wr_data_i | input | 8 | Write data |
| cnt_o | output | 16 | Both counts, high byte from channel 1 |
| pwm_o | output | 2 | Channel outputs |

## Verification
Every result belongs to the single rising edge that takes the stimulus. The count, the buffer loads, the immediate copies and the output level all show up directly after that edge, because the output register is loaded from the next-state values rather than from the present state. The bench changes inputs on the falling edge and compares both `cnt_o` and `pwm_o` on the next falling edge. In the sweep, the k-th enabled tick after a counter write is therefore compared against the count and level computed for position k of the period. Buffer writes are made with the tick held low, so the edge that would apply a buffer is always a known tick.

// File: rtl/bpwm_pkg.sv
`timescale 1ns/1ps
package bpwm_pkg;

    typedef enum logic [1:0] {
        SEL_PER  = 2'd0,
        SEL_DUTY = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } wr_sel_e;

endpackage

// File: rtl/bpwm_step.sv
`timescale 1ns/1ps
// Next count/direction for one tick of a channel of width W.
module bpwm_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic         down_i,
    input  logic [W-1:0] per_i,
    input  logic         run_i,
    input  logic         center_i,
    output logic [W-1:0] cnt_o,
    output logic         down_o,
    output logic         wrap_o
);
    logic [W-1:0] inc;
    logic [W-1:0] dec;
    logic [W-1:0] last;

    assign inc  = cnt_i + W'(1);
    assign dec  = cnt_i - W'(1);
    assign last = per_i - W'(1);

    always_comb begin
        cnt_o  = cnt_i;
        down_o = center_i & down_i;
        wrap_o = 1'b0;
        if (run_i && per_i != '0) begin
            if (!center_i) begin
                if (cnt_i >= last) begin
                    cnt_o  = '0;
                    wrap_o = 1'b1;
                end else begin
                    cnt_o = inc;
                end
            end else if (!down_i) begin
                if (cnt_i >= per_i) begin
                    // held count above a shortened period: turn around
                    cnt_o  = last;
                    down_o = 1'b1;
                end else begin
                    cnt_o  = inc;
                    down_o = (inc == per_i);
                end
            end else if (cnt_i <= W'(1)) begin
                cnt_o  = '0;
                down_o = 1'b0;
                wrap_o = 1'b1;
            end else begin
                cnt_o = dec;
            end
        end
    end
endmodule

// File: rtl/bpwm_level.sv
`timescale 1ns/1ps
// Output level for a given count, direction, period, duty and polarity.
module bpwm_level #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic         down_i,
    input  logic [W-1:0] per_i,
    input  logic [W-1:0] duty_i,
    input  logic         pol_i,
    output logic         level_o
);
    logic active;

    always_comb begin
        if (per_i == '0) begin
            active = 1'b0;
        end else if (duty_i >= per_i) begin
            active = 1'b1;
        end else if (down_i) begin
            active = (cnt_i <= duty_i);
        end else begin
            active = (cnt_i < duty_i);
        end
        level_o = active ? pol_i : ~pol_i;
    end
endmodule

// File: rtl/bpwm_pair.sv
`timescale 1ns/1ps
module bpwm_pair
    import bpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [1:0]      en_i,
    input  logic [1:0]      pol_i,
    input  logic [1:0]      center_i,
    input  logic            concat_i,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_reg_i,
    input  logic            wr_ch_i,
    input  logic [CW-1:0]   wr_data_i,
    output logic [2*CW-1:0] cnt_o,
    output logic [1:0]      pwm_o
);
    localparam int NCH = 2;
    localparam int WW  = NCH * CW;

    typedef struct packed {
        logic [NCH-1:0][CW-1:0] cnt;
        logic [NCH-1:0]         down;
        logic [NCH-1:0][CW-1:0] per_buf;
        logic [NCH-1:0][CW-1:0] duty_buf;
        logic [NCH-1:0][CW-1:0] per_act;
        logic [NCH-1:0][CW-1:0] duty_act;
    } core_t;

    core_t            st_q, st_d;
    logic [NCH-1:0]   out_q, out_d;

    wr_sel_e          wr_sel;
    logic [NCH-1:0]   eff_en, eff_ctr, wr_hit, cw_raw, cw_eff, load_v;

    logic [NCH-1:0][CW-1:0] s8_cnt;
    logic [NCH-1:0]         s8_down, s8_wrap, lv8;
    logic [WW-1:0]          s16_cnt;
    logic                   s16_down, s16_wrap, lv16;

    assign wr_sel = wr_sel_e'(wr_reg_i);

    // Control routing: in joined mode channel 1 drives both bytes.
    always_comb begin
        eff_en[1]  = en_i[1];
        eff_ctr[1] = center_i[1];
        eff_en[0]  = concat_i ? en_i[1]     : en_i[0];
        eff_ctr[0] = concat_i ? center_i[1] : center_i[0];
        for (int i = 0; i < NCH; i++) begin
            wr_hit[i] = wr_en_i && (wr_ch_i == 1'(i));
            cw_raw[i] = wr_hit[i] && (wr_sel == SEL_CNT);
        end
        for (int i = 0; i < NCH; i++) begin
            cw_eff[i] = concat_i ? (|cw_raw) : cw_raw[i];
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_lane
            bpwm_step #(.W(CW)) u_step (
                .cnt_i   (st_q.cnt[g]),
                .down_i  (st_q.down[g]),
                .per_i   (st_q.per_act[g]),
                .run_i   (eff_en[g] & tick_i),
                .center_i(eff_ctr[g]),
                .cnt_o   (s8_cnt[g]),
                .down_o  (s8_down[g]),
                .wrap_o  (s8_wrap[g])
            );
            bpwm_level #(.W(CW)) u_level (
                .cnt_i  (st_d.cnt[g]),
                .down_i (st_d.down[g]),
                .per_i  (st_d.per_act[g]),
                .duty_i (st_d.duty_act[g]),
                .pol_i  (pol_i[g]),
                .level_o(lv8[g])
            );
        end
    endgenerate

    bpwm_step #(.W(WW)) u_step_wide (
        .cnt_i   ({st_q.cnt[1], st_q.cnt[0]}),
        .down_i  (st_q.down[1]),
        .per_i   ({st_q.per_act[1], st_q.per_act[0]}),
        .run_i   (en_i[1] & tick_i),
        .center_i(center_i[1]),
        .cnt_o   (s16_cnt),
        .down_o  (s16_down),
        .wrap_o  (s16_wrap)
    );

    bpwm_level #(.W(WW)) u_level_wide (
        .cnt_i  ({st_d.cnt[1], st_d.cnt[0]}),
        .down_i (st_d.down[1]),
        .per_i  ({st_d.per_act[1], st_d.per_act[0]}),
        .duty_i ({st_d.duty_act[1], st_d.duty_act[0]}),
        .pol_i  (pol_i[1]),
        .level_o(lv16)
    );

    // Next state of counters, buffers and working values.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCH; i++) begin
            if (wr_hit[i] && wr_sel == SEL_PER) begin
                st_d.per_buf[i] = wr_data_i;
                if (!eff_en[i]) st_d.per_act[i] = wr_data_i;
            end
            if (wr_hit[i] && wr_sel == SEL_DUTY) begin
                st_d.duty_buf[i] = wr_data_i;
                if (!eff_en[i]) st_d.duty_act[i] = wr_data_i;
            end
            if (concat_i) begin
                st_d.cnt[i]  = s16_cnt[i*CW +: CW];
                st_d.down[i] = s16_down;
                load_v[i]    = s16_wrap;
            end else begin
                st_d.cnt[i]  = s8_cnt[i];
                st_d.down[i] = s8_down[i];
                load_v[i]    = s8_wrap[i];
            end
            if (cw_eff[i]) begin
                st_d.cnt[i]  = '0;
                st_d.down[i] = 1'b0;
                load_v[i]    = 1'b1;
            end
            if (load_v[i]) begin
                st_d.per_act[i]  = st_d.per_buf[i];
                st_d.duty_act[i] = st_d.duty_buf[i];
            end
        end
    end

    // Output level follows the state being loaded on the same edge.
    always_comb begin
        out_d[1] = concat_i ? lv16 : lv8[1];
        out_d[0] = concat_i ? 1'b0 : lv8[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            out_q <= '0;
        end else begin
            st_q  <= st_d;
            out_q <= out_d;
        end
    end

    assign cnt_o = {st_q.cnt[1], st_q.cnt[0]};
    assign pwm_o = out_q;

    // R10: a zero working period leaves the count in place
    a_r10_zero_period_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!concat_i && st_q.per_act[0] == '0 && !wr_en_i) |=> $stable(st_q.cnt[0]));

    // R4: no enable, no movement
    a_r4_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!concat_i && !en_i[0] && !wr_en_i) |=> $stable(st_q.cnt[0]));

    // R2: edge mode wraps after the last count of the period
    a_r2_left_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!concat_i && en_i[0] && tick_i && !center_i[0] && !wr_en_i &&
         st_q.per_act[0] != '0 && st_q.cnt[0] == st_q.per_act[0] - CW'(1))
        |=> (st_q.cnt[0] == '0));

    // R5: a counter write clears count and direction
    a_r5_count_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel == SEL_CNT && !wr_ch_i && !concat_i)
        |=> (st_q.cnt[0] == '0 && !st_q.down[0]));

    // R12: a write to either byte clears the joined count
    a_r12_joined_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel == SEL_CNT && concat_i) |=> (cnt_o == '0));

    // R12: low output is quiet while joined
    a_r12_low_output_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        concat_i |=> !pwm_o[0]);
endmodule

// File: tb/bpwm_pair_bench.sv
`timescale 1ns/1ps
module bpwm_pair_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_i;
    logic [1:0]  en_i, pol_i, center_i;
    logic        concat_i;
    logic        wr_en_i;
    logic [1:0]  wr_reg_i;
    logic        wr_ch_i;
    logic [7:0]  wr_data_i;
    logic [15:0] cnt_o;
    logic [1:0]  pwm_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bpwm_pair u_bpwm_pair (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(en_i), .pol_i(pol_i),
        .center_i(center_i), .concat_i(concat_i), .wr_en_i(wr_en_i),
        .wr_reg_i(wr_reg_i), .wr_ch_i(wr_ch_i), .wr_data_i(wr_data_i),
        .cnt_o(cnt_o), .pwm_o(pwm_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic ch, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_reg_i = sel; wr_ch_i = ch; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    function automatic logic lvl(input int c, input bit down, input int p, input int d, input bit pol);
        bit act;
        act = (p != 0) && ((d >= p) || (down ? (c <= d) : (c < d)));
        return act ? pol : ~pol;
    endfunction

    task automatic run_cfg(input int ch, input int p, input int d, input bit c, input bit pol);
        int len;
        int ec, m;
        bit dn;
        string tag;
        en_i = 2'b00; tick_i = 1'b0; concat_i = 1'b0;
        pol_i = {pol, pol}; center_i = {c, c};
        wr(2'd0, 1'(ch), 8'(p));
        wr(2'd1, 1'(ch), 8'(d));
        wr(2'd2, 1'(ch), 8'hA5);
        chk("R5", 32'(cnt_o[ch*8 +: 8]), 0);
        chk("R5", 32'(pwm_o[ch]), 32'(lvl(0, 1'b0, p, d, pol)));
        en_i[ch] = 1'b1; tick_i = 1'b1;
        len = (p == 0) ? 4 : ((c ? 2 * p : p) + 3);
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            if (p == 0) begin
                ec = 0; dn = 1'b0;
            end else if (!c) begin
                ec = k % p; dn = 1'b0;
            end else begin
                m  = k % (2 * p);
                ec = (m <= p) ? m : 2 * p - m;
                dn = (m >= p);
            end
            if (p == 0)      tag = "R10";
            else if (d >= p) tag = "R11";
            else if (d == 0) tag = "R11";
            else if (c)      tag = "R9";
            else             tag = "R8";
            chk(p == 0 ? "R10" : (c ? "R3" : "R2"), 32'(cnt_o[ch*8 +: 8]), 32'(ec));
            chk(tag, 32'(pwm_o[ch]), 32'(lvl(ec, dn, p, d, pol)));
        end
        en_i = 2'b00; tick_i = 1'b0;
    endtask

    initial begin
        #(150000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick_i = 1'b0; en_i = 2'b00; pol_i = 2'b00; center_i = 2'b00;
        concat_i = 1'b0; wr_en_i = 1'b0; wr_reg_i = 2'd3; wr_ch_i = 1'b0; wr_data_i = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1", 32'(cnt_o), 0);
        chk("R1", 32'(pwm_o), 0);
        rst_n = 1'b1;

        // Sweep: both lanes, both polarities, both shapes, small periods and duties
        for (int ch = 0; ch < 2; ch++)
            for (int pol = 0; pol < 2; pol++)
                for (int c = 0; c < 2; c++)
                    for (int p = 0; p < 6; p++)
                        for (int d = 0; d < 7; d++)
                            run_cfg(ch, p, d, 1'(c), 1'(pol));

        // R4: hold while disabled or without tick
        pol_i = 2'b11; center_i = 2'b00;
        wr(2'd0, 1'b0, 8'd10); wr(2'd1, 1'b0, 8'd5); wr(2'd2, 1'b0, 8'd0);
        en_i = 2'b01; tick_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4", 32'(cnt_o[7:0]), 3);
        en_i = 2'b00;
        repeat (4) @(negedge clk);
        chk("R4", 32'(cnt_o[7:0]), 3);
        en_i = 2'b01; tick_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4", 32'(cnt_o[7:0]), 3);
        tick_i = 1'b1;
        @(negedge clk);
        chk("R4", 32'(cnt_o[7:0]), 4);
        en_i = 2'b00; tick_i = 1'b0;

        // R6: buffered writes while running
        wr(2'd0, 1'b0, 8'd4); wr(2'd1, 1'b0, 8'd1); wr(2'd2, 1'b0, 8'd0);
        en_i = 2'b01; tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        wr(2'd0, 1'b0, 8'd6); wr(2'd1, 1'b0, 8'd5);
        chk("R6", 32'(cnt_o[7:0]), 1);
        chk("R6", 32'(pwm_o[0]), 0);
        tick_i = 1'b1;
        @(negedge clk);
        chk("R6", 32'(pwm_o[0]), 0);
        repeat (2) @(negedge clk);
        chk("R6", 32'(cnt_o[7:0]), 0);
        chk("R6", 32'(pwm_o[0]), 1);
        repeat (4) @(negedge clk);
        chk("R6", 32'(cnt_o[7:0]), 4);
        chk("R6", 32'(pwm_o[0]), 1);
        @(negedge clk);
        chk("R6", 32'(cnt_o[7:0]), 5);
        chk("R6", 32'(pwm_o[0]), 0);

        // R5: counter write applies the buffered period at once
        tick_i = 1'b0;
        wr(2'd0, 1'b0, 8'd3);
        wr(2'd2, 1'b0, 8'hFF);
        chk("R5", 32'(cnt_o[7:0]), 0);
        chk("R5", 32'(pwm_o[0]), 1);
        tick_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5", 32'(cnt_o[7:0]), 2);
        @(negedge clk);
        chk("R5", 32'(cnt_o[7:0]), 0);
        en_i = 2'b00; tick_i = 1'b0;

        // R5: counter write during the descent restores upward counting
        center_i = 2'b01;
        wr(2'd0, 1'b0, 8'd4); wr(2'd1, 1'b0, 8'd2); wr(2'd2, 1'b0, 8'd0);
        en_i = 2'b01; tick_i = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3", 32'(cnt_o[7:0]), 3);
        tick_i = 1'b0;
        wr(2'd2, 1'b0, 8'h33);
        tick_i = 1'b1;
        @(negedge clk);
        chk("R5", 32'(cnt_o[7:0]), 1);
        en_i = 2'b00; tick_i = 1'b0; center_i = 2'b00;

        // R7: writes to a disabled channel act at once; code 3 is ignored
        wr(2'd0, 1'b0, 8'd6); wr(2'd1, 1'b0, 8'd0); wr(2'd2, 1'b0, 8'd0);
        chk("R7", 32'(pwm_o[0]), 0);
        wr(2'd1, 1'b0, 8'd3);
        chk("R7", 32'(pwm_o[0]), 1);
        wr(2'd3, 1'b0, 8'd0);
        chk("R7", 32'(pwm_o[0]), 1);
        chk("R7", 32'(cnt_o[7:0]), 0);
        en_i = 2'b01; tick_i = 1'b1;
        @(negedge clk);
        chk("R7", 32'(cnt_o[7:0]), 1);
        en_i = 2'b00; tick_i = 1'b0;

        // R12/R13: joined 16-bit channel, period 258, duty 128
        concat_i = 1'b1; pol_i = 2'b10; center_i = 2'b00;
        wr(2'd0, 1'b0, 8'h02); wr(2'd0, 1'b1, 8'h01);
        wr(2'd1, 1'b0, 8'h80); wr(2'd1, 1'b1, 8'h00);
        wr(2'd2, 1'b0, 8'h00);
        chk("R12", 32'(cnt_o), 0);
        chk("R12", 32'(pwm_o[1]), 1);
        en_i = 2'b10; tick_i = 1'b1;
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            chk("R12", 32'(cnt_o), 32'(k % 258));
            chk("R12", 32'(pwm_o[1]), ((k % 258) < 128) ? 1 : 0);
            chk("R12", 32'(pwm_o[0]), 0);
            if (k == 255) chk("R13", 32'(cnt_o), 32'h00FF);
            if (k == 256) begin
                chk("R13", 32'(cnt_o[15:8]), 1);
                chk("R13", 32'(cnt_o[7:0]), 0);
            end
        end
        tick_i = 1'b0;
        wr(2'd2, 1'b1, 8'h7E);
        chk("R12", 32'(cnt_o), 0);
        en_i = 2'b01; tick_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12", 32'(cnt_o), 0);
        en_i = 2'b00; tick_i = 1'b0; concat_i = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule